// File: doc/BRIEF.md
# Pad wakeup pattern detector

A bank of independent detectors clocked by the always-on clock. Each detector picks one pad out of two pad groups (muxed pads or dedicated pads), passes the pad value through an optional stability filter, and watches the filtered level for a configured pattern: a falling, rising or either-direction edge, or the pad held low or held high for a programmable number of cycles. A hit sets that detector's sticky cause bit, and the registered OR of all cause bits forms the wakeup request for the power controller. Pad inputs are taken as already synchronous to this clock; configuration arrives as flat per-detector vectors and is assumed to be settled before the wakeup path matters.

Each detector is steered by a small state machine with three named states. ST_OFF holds while the detector is inactive, and for one cycle after any configuration change; in it the edge history, the filter window and the level counter are reloaded from the current pad. ST_EDGE and ST_LEVEL are the watching states for the edge modes and the timed modes. The transitions are: ARM_EDGE (ST_OFF to ST_EDGE when the detector is active, its mode is an edge mode and its configuration is unchanged); ARM_LEVEL (ST_OFF to ST_LEVEL, the same for a timed mode); DISARM (ST_EDGE or ST_LEVEL back to ST_OFF when the detector turns inactive or any configuration bit changes). Every other case keeps the state.

Software clears a cause bit by pulsing its clear input. In a cycle where a detector both hits and is cleared, the hit wins.

Top module: `pad_wake_detect`

## Requirements
- R1: Edge modes act on the filtered level: mode code 1 fires on a 1-to-0 change, code 2 on a 0-to-1 change, code 3 on a change either way.
- R2: Timed modes: code 4 targets level 0, code 5 targets level 1. A counter clears on every cycle where the filtered level differs from the target. A hit occurs on a matching cycle whose count of earlier consecutive matching cycles has reached the threshold, so the level must persist for threshold+1 sampled cycles, and a threshold of 0 fires on the first matching cycle.
- R3: With the filter bit set, a new pad value reaches the detector only after 4 consecutive equal samples; shorter pulses are dropped, and accepted changes arrive 3 cycles later than without the filter.
- R4: With group bit 0 the 5-bit index uses offset coding: indices 0 and 1 select constant 0, and index n >= 2 selects muxed pad n-2 (constant 0 if that pad does not exist).
- R5: With group bit 1 the index selects the dedicated pad of the same number; an index at or beyond the dedicated pad count selects constant 0.
- R6: A detector never sets its cause bit while its enable bit is 0 or its mode code is 0, 6 or 7.
- R7: A cause bit is set by a hit and holds until its clear input is 1 on a clock edge; a hit in the same cycle as a clear leaves the bit set.
- R8: The wakeup request is the OR of all cause bits, registered once: it rises one cycle after the first cause bit rises and falls one cycle after the last one clears.
- R9: Enabling a detector or changing any of its configuration fields causes no detection from the old pad, old filter state or old level: the history is reloaded from the newly selected pad.
- R10: Without the filter, a pad edge sampled on one clock edge sets the matching cause bit on the following clock edge.
- R11: During reset every cause bit and the wakeup request are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| muxed_pads | input | NMux | Values of the muxed pads |
| ded_pads | input | NDed | Values of the dedicated pads |
| det_en | input | NDet | Per-detector enable |
| det_mode | input | 3*NDet | Per-detector mode code, detector i at bits 3i+2..3i |
| det_filt | input | NDet | Per-detector filter enable |
| det_grp | input | NDet | Per-detector pad group, 0 muxed, 1 dedicated |
| det_idx | input | IdxW*NDet | Per-detector pad index, detector i at bits IdxW*i upward |
| det_thresh | input | CntW*NDet | Per-detector cycle threshold for the timed modes |
| cause_clr | input | NDet | Per-detector clear pulse for the cause bit |
| cause | output | NDet | Sticky per-detector cause bits |
| wake_req | output | 1 | Registered OR of all cause bits |

## Verification
The bench builds the block with its defaults: 8 detectors, 32 muxed pads, 15 dedicated pads, a 5-bit index and an 8-bit counter. With only 15 dedicated pads, indices 15 to 31 in the dedicated group fall outside the pad range and the constant-0 fallback is exercised, while in the muxed group the constant indices 0 and 1 are exercised, including a timed-low mode that fires on that constant. The 8-bit threshold allows timed runs that stop exactly one cycle short of and exactly at the firing length, and several detectors can be active at once to check the OR and per-bit clearing.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    typedef enum logic [2:0] {
        MD_NONE   = 3'd0,
        MD_FALL   = 3'd1,
        MD_RISE   = 3'd2,
        MD_EITHER = 3'd3,
        MD_LOW    = 3'd4,
        MD_HIGH   = 3'd5
    } wake_mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EDGE  = 2'd1,
        ST_LEVEL = 2'd2
    } det_state_e;

    localparam int unsigned ModeW     = 3;
    localparam int unsigned FiltDepth = 4;

    function automatic logic mode_active(input logic [2:0] m);
        return (m == MD_FALL) || (m == MD_RISE) || (m == MD_EITHER) ||
               (m == MD_LOW)  || (m == MD_HIGH);
    endfunction

    function automatic logic mode_timed(input logic [2:0] m);
        return (m == MD_LOW) || (m == MD_HIGH);
    endfunction

endpackage

// File: rtl/pwd_padsel.sv
module pwd_padsel #(
    parameter int unsigned NMux = 32,
    parameter int unsigned NDed = 15,
    parameter int unsigned IdxW = 5
) (
    input  logic [NMux-1:0] muxed_pads,
    input  logic [NDed-1:0] ded_pads,
    input  logic            grp,
    input  logic [IdxW-1:0] idx,
    output logic            raw
);

    // Offset of the first real pad in muxed-group coding.
    localparam int unsigned MuxOfs = 2;

    always_comb begin
        raw = 1'b0;
        if (grp) begin
            for (int p = 0; p < int'(NDed); p++) begin
                if (int'(idx) == p) raw = ded_pads[p];
            end
        end else begin
            for (int p = 0; p < int'(NMux); p++) begin
                if (int'(idx) == p + int'(MuxOfs)) raw = muxed_pads[p];
            end
        end
    end

endmodule

// File: rtl/pwd_filter.sv
module pwd_filter
    import pwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic filt_en,
    input  logic load,
    output logic level
);

    localparam int unsigned HistW = FiltDepth - 1;

    logic [HistW-1:0]     hist_q;
    logic [FiltDepth-1:0] window;

    assign window = {hist_q, raw};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            level  <= 1'b0;
        end else if (load) begin
            hist_q <= {HistW{raw}};
            level  <= raw;
        end else begin
            hist_q <= window[HistW-1:0];
            if (!filt_en) begin
                level <= raw;
            end else if (&window) begin
                level <= 1'b1;
            end else if (~|window) begin
                level <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwd_core.sv
module pwd_core
    import pwd_pkg::*;
#(
    parameter int unsigned CntW = 8,
    parameter int unsigned KeyW = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [2:0]      mode,
    input  logic [CntW-1:0] thresh,
    input  logic [KeyW-1:0] cfg_key,
    input  logic            raw,
    input  logic            level,
    input  logic            clr,
    output logic            load,
    output logic            cause
);

    det_state_e      state_q, state_d;
    logic [KeyW-1:0] key_q;
    logic [CntW-1:0] cnt_q;
    logic            prev_q;
    logic            active, changed, target, match, hit;

    assign active  = en && mode_active(mode);
    assign changed = (cfg_key != key_q);
    assign target  = (mode == MD_HIGH);
    assign match   = (level == target);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: ARM_EDGE, ARM_LEVEL, DISARM.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (active && !changed) begin
                    state_d = mode_timed(mode) ? ST_LEVEL : ST_EDGE;
                end
            end
            ST_EDGE, ST_LEVEL: begin
                if (!active || changed) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        load = 1'b0;
        hit  = 1'b0;
        unique case (state_q)
            ST_OFF: load = 1'b1;
            ST_EDGE: begin
                if (!changed) begin
                    hit = ((mode == MD_FALL)   &&  prev_q && !level) ||
                          ((mode == MD_RISE)   && !prev_q &&  level) ||
                          ((mode == MD_EITHER) && (prev_q != level));
                end
            end
            ST_LEVEL: hit = !changed && match && (cnt_q >= thresh);
            default: load = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            prev_q <= 1'b0;
            cnt_q  <= '0;
            cause  <= 1'b0;
        end else begin
            key_q  <= cfg_key;
            prev_q <= load ? raw : level;
            if (state_q != ST_LEVEL || !match) begin
                cnt_q <= '0;
            end else if (cnt_q != {CntW{1'b1}}) begin
                cnt_q <= cnt_q + 1'b1;
            end
            cause <= (cause & ~clr) | hit;
        end
    end

endmodule

// File: rtl/pad_wake_detect.sv
module pad_wake_detect
    import pwd_pkg::*;
#(
    parameter int unsigned NDet = 8,
    parameter int unsigned NMux = 32,
    parameter int unsigned NDed = 15,
    parameter int unsigned IdxW = 5,
    parameter int unsigned CntW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NMux-1:0]      muxed_pads,
    input  logic [NDed-1:0]      ded_pads,
    input  logic [NDet-1:0]      det_en,
    input  logic [NDet*3-1:0]    det_mode,
    input  logic [NDet-1:0]      det_filt,
    input  logic [NDet-1:0]      det_grp,
    input  logic [NDet*IdxW-1:0] det_idx,
    input  logic [NDet*CntW-1:0] det_thresh,
    input  logic [NDet-1:0]      cause_clr,
    output logic [NDet-1:0]      cause,
    output logic                 wake_req
);

    localparam int unsigned KeyW = 1 + ModeW + 1 + 1 + IdxW + CntW;

    for (genvar i = 0; i < NDet; i++) begin : g_det
        logic [2:0]      mode_i;
        logic [IdxW-1:0] idx_i;
        logic [CntW-1:0] thr_i;
        logic [KeyW-1:0] key_i;
        logic            raw_i, level_i, load_i;

        assign mode_i = det_mode[i*ModeW +: ModeW];
        assign idx_i  = det_idx[i*IdxW +: IdxW];
        assign thr_i  = det_thresh[i*CntW +: CntW];
        assign key_i  = {det_en[i], mode_i, det_filt[i], det_grp[i], idx_i, thr_i};

        pwd_padsel #(.NMux(NMux), .NDed(NDed), .IdxW(IdxW)) u_sel (
            .muxed_pads (muxed_pads),
            .ded_pads   (ded_pads),
            .grp        (det_grp[i]),
            .idx        (idx_i),
            .raw        (raw_i)
        );

        pwd_filter u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_i),
            .filt_en (det_filt[i]),
            .load    (load_i),
            .level   (level_i)
        );

        pwd_core #(.CntW(CntW), .KeyW(KeyW)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (det_en[i]),
            .mode    (mode_i),
            .thresh  (thr_i),
            .cfg_key (key_i),
            .raw     (raw_i),
            .level   (level_i),
            .clr     (cause_clr[i]),
            .load    (load_i),
            .cause   (cause[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= |cause;
    end

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
    parameter int unsigned NDet = 8,
    parameter int unsigned IdxW = 5,
    parameter int unsigned CntW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NDet-1:0]      det_en,
    input logic [NDet*3-1:0]    det_mode,
    input logic [NDet-1:0]      det_filt,
    input logic [NDet-1:0]      det_grp,
    input logic [NDet*IdxW-1:0] det_idx,
    input logic [NDet*CntW-1:0] det_thresh,
    input logic [NDet-1:0]      cause_clr,
    input logic [NDet-1:0]      cause,
    input logic                 wake_req
);

    localparam int unsigned CfgW = 1 + 3 + 1 + 1 + IdxW + CntW;

    logic [NDet-1:0] idle_det;

    always_comb begin
        for (int i = 0; i < int'(NDet); i++) begin
            idle_det[i] = !det_en[i] || (det_mode[i*3 +: 3] == 3'd0) ||
                          (det_mode[i*3 +: 3] > 3'd5);
        end
    end

    // R11: reset clears causes and the request.
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cause == '0) && !wake_req);

    // R8: request follows the OR of causes one cycle later.
    a_r8_wake_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause) |=> wake_req);
    a_r8_wake_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cause) |=> !wake_req);

    // R7: a cause bit only drops after a clear.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~cause & $past(cause) & ~$past(cause_clr)) == '0));

    // R6: an inactive detector never raises its cause.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & $past(idle_det)) == '0));

    for (genvar i = 0; i < NDet; i++) begin : g_chk
        logic [CfgW-1:0] cfg_i;
        assign cfg_i = {det_en[i], det_mode[i*3 +: 3], det_filt[i], det_grp[i],
                        det_idx[i*IdxW +: IdxW], det_thresh[i*CntW +: CntW]};

        // R9: no detection in the cycle a configuration changes.
        a_r9_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i != $past(cfg_i)) |=> !$rose(cause[i]));
    end

endmodule

bind pad_wake_detect pwd_checker #(
    .NDet (NDet),
    .IdxW (IdxW),
    .CntW (CntW)
) u_pwd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_en     (det_en),
    .det_mode   (det_mode),
    .det_filt   (det_filt),
    .det_grp    (det_grp),
    .det_idx    (det_idx),
    .det_thresh (det_thresh),
    .cause_clr  (cause_clr),
    .cause      (cause),
    .wake_req   (wake_req)
);

// File: tb/tb_pad_wake_detect.sv
`timescale 1ns/1ps
module tb_pad_wake_detect;

    localparam int NDet = 8;
    localparam int NMux = 32;
    localparam int NDed = 15;
    localparam int IdxW = 5;
    localparam int CntW = 8;
    localparam int NRows = 17;

    // Row: [27:25] mode [24] filt [23] grp [22:18] idx [17:10] thr
    //      [9:2] pulse length [1] pulse all other pads [0] expected cause
    localparam logic [27:0] ROWS [NRows] = '{
        {3'd2, 1'b0, 1'b0, 5'd7,  8'd0, 8'd2, 1'b0, 1'b1}, // R1 R4 rise mux pad 5
        {3'd1, 1'b0, 1'b0, 5'd2,  8'd0, 8'd1, 1'b0, 1'b1}, // R1 fall mux pad 0
        {3'd3, 1'b0, 1'b1, 5'd3,  8'd0, 8'd1, 1'b0, 1'b1}, // R1 R5 either ded 3
        {3'd2, 1'b1, 1'b0, 5'd9,  8'd0, 8'd3, 1'b0, 1'b0}, // R3 short pulse dropped
        {3'd2, 1'b1, 1'b0, 5'd9,  8'd0, 8'd4, 1'b0, 1'b1}, // R3 four samples pass
        {3'd5, 1'b0, 1'b1, 5'd0,  8'd3, 8'd3, 1'b0, 1'b0}, // R2 one short
        {3'd5, 1'b0, 1'b1, 5'd0,  8'd3, 8'd4, 1'b0, 1'b1}, // R2 exact length
        {3'd4, 1'b0, 1'b0, 5'd10, 8'd5, 8'd6, 1'b0, 1'b1}, // R2 low exact
        {3'd4, 1'b0, 1'b0, 5'd10, 8'd5, 8'd5, 1'b0, 1'b0}, // R2 low one short
        {3'd4, 1'b1, 1'b1, 5'd14, 8'd2, 8'd4, 1'b0, 1'b1}, // R2 R3 filtered low
        {3'd5, 1'b0, 1'b0, 5'd3,  8'd0, 8'd1, 1'b0, 1'b1}, // R2 threshold zero
        {3'd6, 1'b0, 1'b0, 5'd7,  8'd0, 8'd4, 1'b0, 1'b0}, // R6 code 6
        {3'd7, 1'b0, 1'b0, 5'd7,  8'd0, 8'd4, 1'b0, 1'b0}, // R6 code 7
        {3'd2, 1'b0, 1'b0, 5'd1,  8'd0, 8'd4, 1'b1, 1'b0}, // R4 constant index
        {3'd4, 1'b0, 1'b0, 5'd0,  8'd2, 8'd1, 1'b0, 1'b1}, // R4 constant 0 held low
        {3'd2, 1'b0, 1'b0, 5'd7,  8'd0, 8'd4, 1'b1, 1'b0}, // R4 other pads only
        {3'd2, 1'b0, 1'b1, 5'd20, 8'd0, 8'd4, 1'b1, 1'b0}  // R5 out of range
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NMux-1:0]      muxed_pads = '0;
    logic [NDed-1:0]      ded_pads = '0;
    logic [NDet-1:0]      det_en = '0;
    logic [NDet*3-1:0]    det_mode = '0;
    logic [NDet-1:0]      det_filt = '0;
    logic [NDet-1:0]      det_grp = '0;
    logic [NDet*IdxW-1:0] det_idx = '0;
    logic [NDet*CntW-1:0] det_thresh = '0;
    logic [NDet-1:0]      cause_clr = '0;
    logic [NDet-1:0]      cause;
    logic                 wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pad_wake_detect #(.NDet(NDet), .NMux(NMux), .NDed(NDed), .IdxW(IdxW), .CntW(CntW)) dut (
        .clk(clk), .rst_n(rst_n), .muxed_pads(muxed_pads), .ded_pads(ded_pads),
        .det_en(det_en), .det_mode(det_mode), .det_filt(det_filt), .det_grp(det_grp),
        .det_idx(det_idx), .det_thresh(det_thresh), .cause_clr(cause_clr),
        .cause(cause), .wake_req(wake_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic set_det(input int i, input logic en, input logic [2:0] m,
                           input logic f, input logic g, input logic [4:0] ix,
                           input logic [7:0] th);
        det_en[i]            = en;
        det_mode[i*3 +: 3]   = m;
        det_filt[i]          = f;
        det_grp[i]           = g;
        det_idx[i*IdxW +: IdxW] = ix;
        det_thresh[i*CntW +: CntW] = th;
    endtask

    // Drive all pads: idle level, target or non-targets at active level.
    task automatic drive(input logic g, input int ix, input logic oth,
                         input logic act_on, input logic actv, input logic idle);
        int tgt;
        bit tv;
        tv  = 1'b0;
        tgt = 0;
        if (!g && ix >= 2 && ix - 2 < NMux) begin tv = 1'b1; tgt = ix - 2; end
        if (g && ix < NDed) begin tv = 1'b1; tgt = ix; end
        for (int p = 0; p < NMux; p++) begin
            bit is_t;
            is_t = tv && !g && (p == tgt);
            muxed_pads[p] = (act_on && (oth ? !is_t : is_t)) ? actv : idle;
        end
        for (int p = 0; p < NDed; p++) begin
            bit is_t;
            is_t = tv && g && (p == tgt);
            ded_pads[p] = (act_on && (oth ? !is_t : is_t)) ? actv : idle;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        tick(3);
        chk("R11 cause in reset", |cause, 1'b0);
        chk("R11 wake in reset", wake_req, 1'b0);
        rst_n = 1'b1;
        tick(2);
        chk("R11 cause after reset", |cause, 1'b0);

        // Table walk on detector 0
        for (int r = 0; r < NRows; r++) begin
            logic [27:0] row;
            logic [2:0] m;
            logic actv;
            row  = ROWS[r];
            m    = row[27:25];
            actv = !((m == 3'd1) || (m == 3'd4));
            det_en = '0;
            cause_clr = '1;
            drive(row[23], int'(row[22:18]), row[1], 1'b0, actv, ~actv);
            tick(2);
            cause_clr = '0;
            set_det(0, 1'b1, m, row[24], row[23], row[22:18], row[17:10]);
            tick(8);
            drive(row[23], int'(row[22:18]), row[1], 1'b1, actv, ~actv);
            tick(int'(row[9:2]));
            drive(row[23], int'(row[22:18]), row[1], 1'b0, actv, ~actv);
            tick(14);
            chk($sformatf("R1 R2 R3 R4 R5 R6 row %0d cause", r), cause[0], row[0]);
            chk($sformatf("R8 row %0d wake", r), wake_req, row[0]);
        end

        // R10 R8 latency, rising on muxed pad 0
        det_en = '0; cause_clr = '1; muxed_pads = '0; ded_pads = '0;
        tick(2);
        cause_clr = '0;
        set_det(0, 1'b1, 3'd2, 1'b0, 1'b0, 5'd2, 8'd0);
        tick(6);
        muxed_pads[0] = 1'b1;
        tick(1);
        chk("R10 cause one edge after", cause[0], 1'b0);
        tick(1);
        chk("R10 cause two edges after", cause[0], 1'b1);
        chk("R8 wake lags cause", wake_req, 1'b0);
        tick(1);
        chk("R8 wake rises", wake_req, 1'b1);

        // R7 sticky, then clear
        muxed_pads[0] = 1'b0;
        tick(5);
        chk("R7 cause holds", cause[0], 1'b1);
        cause_clr[0] = 1'b1;
        tick(1);
        cause_clr[0] = 1'b0;
        chk("R7 cleared", cause[0], 1'b0);
        chk("R8 wake still high", wake_req, 1'b1);
        tick(1);
        chk("R8 wake falls", wake_req, 1'b0);

        // R7 hit beats clear: held high, threshold 0
        set_det(0, 1'b1, 3'd5, 1'b0, 1'b0, 5'd2, 8'd0);
        muxed_pads[0] = 1'b1;
        tick(6);
        chk("R7 timed high set", cause[0], 1'b1);
        cause_clr[0] = 1'b1;
        tick(3);
        chk("R7 set wins over clear", cause[0], 1'b1);
        det_en[0] = 1'b0;
        tick(2);
        cause_clr[0] = 1'b0;
        chk("R7 clear after disable", cause[0], 1'b0);
        muxed_pads = '0;

        // R6 enable gating
        set_det(4, 1'b0, 3'd2, 1'b0, 1'b0, 5'd8, 8'd0);
        tick(4);
        muxed_pads[6] = 1'b1;
        tick(6);
        chk("R6 disabled detector quiet", cause[4], 1'b0);
        muxed_pads[6] = 1'b0;

        // R8 OR of two detectors
        set_det(1, 1'b1, 3'd2, 1'b0, 1'b1, 5'd2, 8'd0);
        set_det(2, 1'b1, 3'd2, 1'b0, 1'b1, 5'd5, 8'd0);
        tick(6);
        ded_pads[2] = 1'b1;
        ded_pads[5] = 1'b1;
        tick(4);
        chk("R8 det1 set", cause[1], 1'b1);
        chk("R8 det2 set", cause[2], 1'b1);
        cause_clr[1] = 1'b1;
        tick(1);
        cause_clr[1] = 1'b0;
        tick(2);
        chk("R8 wake held by det2", wake_req, 1'b1);
        cause_clr[2] = 1'b1;
        tick(1);
        cause_clr[2] = 1'b0;
        tick(1);
        chk("R8 wake drops after last clear", wake_req, 1'b0);
        det_en = '0;
        ded_pads = '0;

        // R9 reconfiguration without false edge
        muxed_pads[2] = 1'b0;
        muxed_pads[3] = 1'b1;
        set_det(3, 1'b1, 3'd2, 1'b0, 1'b0, 5'd4, 8'd0);
        tick(6);
        set_det(3, 1'b1, 3'd2, 1'b0, 1'b0, 5'd5, 8'd0);
        tick(10);
        chk("R9 switch to high pad", cause[3], 1'b0);
        set_det(3, 1'b1, 3'd1, 1'b1, 1'b0, 5'd4, 8'd0);
        tick(10);
        chk("R9 filtered switch to low pad", cause[3], 1'b0);
        muxed_pads[2] = 1'b1;
        tick(6);
        muxed_pads[2] = 1'b0;
        tick(8);
        chk("R9 R3 later real edge", cause[3], 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule